// File: doc/BRIEF.md
# Fan PWM Generator with Register Control

The block drives one pulse-width-modulated line for a two-wire fan. Software programs it through a small word-addressed register port with one request strobe and a write qualifier: a control word carries the run bit, a mode bit and an 8-bit duty value, and a second word stores a 16-bit maximum-speed value. The speed value is kept only so that software can read it back.

The period is fixed. A prescaler divides the clock by `DIV`, and a step counter splits each period into 255 equal steps. The output is high during the leading `duty` steps of each period, so the high time is duty/255 of the period. With the default `DIV`, a 100 MHz clock gives a period of about 40 ms. A duty write acts on the running period at once, so the period in which the write lands can combine the old and new values. Clearing the run bit forces the output low and discards the position in the period. Setting it again starts a new period.

Top module: `fan_pwm_top`

## Requirements
- R1: After reset the control word reads 0, the speed word reads 4000 (0x0FA0), and pwm_o is low.
- R2: Control word at offset 0x0: bit 0 is run (1 = on), bit 1 is mode, bits 23:16 are duty. Every other bit reads as 0 and ignores writes.
- R3: Speed word at offset 0x4: bits 15:0 are stored and read back. Bits 31:16 read as 0.
- R4: A read (req_i=1, we_i=0) updates rdata_o at the clock edge that samples it. Offsets other than 0x0 and 0x4 read as 0, and writes to them change no register.
- R5: While running, one period lasts 255*DIV cycles. The output is high from the start of the period for duty*DIV cycles and low for the rest.
- R6: Duty 0 keeps pwm_o low for the whole period. Duty 255 keeps it high through every period, including the wrap.
- R7: A write that clears run drives pwm_o low from the edge that takes the write, and pwm_o stays low while run is 0.
- R8: A write that sets run starts a new period at step 0, whatever step was reached before the stop.
- R9: A duty write while running takes effect at the current step of the current period. Every later period uses only the new value.
- R10: The mode bit is stored and read back but does not change the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the register, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, updated on the read edge |
| pwm_o | output | 1 | Fan PWM output, high during the active part of each period |

## Verification
The waveform is measured by counting high cycles over whole periods for duty values 0, 10, 128, 200 and 255. The count separates a correct duty scale from an off-by-one step threshold. The all-high case also shows whether a glitch occurs at the wrap. A duty change in the middle of a period distinguishes immediate use of the new value from a deferred, shadowed update, because the high count of the mixed period differs between the two. A stop in the middle of a period followed by a restart shows whether the step position was discarded. Register tests with all-ones data and unmapped offsets separate stored bits from bits that read as zero, and confirm that unmapped writes leave both words unchanged.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;
  localparam int unsigned CTRL_OFS  = 0;
  localparam int unsigned SPD_OFS   = 4;
  localparam int unsigned RUN_BIT   = 0;
  localparam int unsigned MODE_BIT  = 1;
  localparam int unsigned DUTY_LSB  = 16;
  localparam int unsigned DUTY_W    = 8;
  localparam int unsigned SPD_W     = 16;
  localparam logic [15:0] SPD_RST   = 16'd4000;
  localparam int unsigned STEPS     = 255;

  typedef struct packed {
    logic [DUTY_W-1:0] duty;
    logic              mode;
    logic              run;
  } ctrl_t;
endpackage

// File: rtl/fan_pwm_prescale.sv
module fan_pwm_prescale #(
  parameter int unsigned DIV = 15686
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i)          cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/fan_pwm_steps.sv
module fan_pwm_steps #(
  parameter int unsigned STEPS = 255,
  parameter int unsigned SW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  output logic [SW-1:0] step_o
);
  localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      step_o <= '0;
    else if (!run_i)  step_o <= '0;   // position is discarded on stop
    else if (tick_i)  step_o <= (step_o == LAST) ? '0 : step_o + 1'b1;
  end
endmodule

// File: rtl/fan_pwm_regs.sv
module fan_pwm_regs
  import fan_pwm_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output ctrl_t             ctrl_o
);
  logic [SPD_W-1:0] spd_q;
  logic [31:0]      rd_mux;
  logic             hit_ctrl, hit_spd;

  assign hit_ctrl = (addr_i == ADDR_W'(CTRL_OFS));
  assign hit_spd  = (addr_i == ADDR_W'(SPD_OFS));

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) begin
      rd_mux[RUN_BIT]                 = ctrl_o.run;
      rd_mux[MODE_BIT]                = ctrl_o.mode;
      rd_mux[DUTY_LSB +: DUTY_W]      = ctrl_o.duty;
    end else if (hit_spd) begin
      rd_mux[SPD_W-1:0]               = spd_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o  <= '0;
      spd_q   <= SPD_RST;
      rdata_o <= '0;
    end else if (req_i) begin
      if (we_i) begin
        if (hit_ctrl) begin
          ctrl_o.run  <= wdata_i[RUN_BIT];
          ctrl_o.mode <= wdata_i[MODE_BIT];
          ctrl_o.duty <= wdata_i[DUTY_LSB +: DUTY_W];
        end else if (hit_spd) begin
          spd_q <= wdata_i[SPD_W-1:0];
        end
      end else begin
        rdata_o <= rd_mux;
      end
    end
  end
endmodule

// File: rtl/fan_pwm_top.sv
module fan_pwm_top
  import fan_pwm_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DIV    = 15686
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              pwm_o
);
  ctrl_t             ctrl;
  logic              tick;
  logic [DUTY_W-1:0] step_q;

  fan_pwm_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .ctrl_o(ctrl)
  );

  fan_pwm_prescale #(.DIV(DIV)) u_pre (
    .clk_i, .rst_ni, .run_i(ctrl.run), .tick_o(tick)
  );

  fan_pwm_steps #(.STEPS(STEPS), .SW(DUTY_W)) u_steps (
    .clk_i, .rst_ni, .run_i(ctrl.run), .tick_i(tick), .step_o(step_q)
  );

  // Steps run 0..254, so duty 255 compares true on every step.
  assign pwm_o = ctrl.run && (step_q < ctrl.duty);
endmodule

module fan_pwm_chk #(
  parameter int unsigned STEPS = 255
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] rdata_o,
  input logic        run_i,
  input logic [7:0]  duty_i,
  input logic [7:0]  step_i,
  input logic        pwm_o
);
  p_rdata_hi_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[31:24] == 8'h00);
  p_step_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i < 8'(STEPS));
  p_step_seq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && step_i != $past(step_i)) |->
      (step_i == $past(step_i) + 8'd1 || step_i == 8'd0));
  p_zero_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_i == 8'd0) |-> !pwm_o);
  p_full_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && duty_i == 8'hFF) |-> pwm_o);
  p_off_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !pwm_o);
  p_fresh_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> (step_i == 8'd0 && pwm_o == (duty_i != 8'd0)));
endmodule

bind fan_pwm_top fan_pwm_chk #(.STEPS(fan_pwm_pkg::STEPS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rdata_o(rdata_o),
  .run_i(ctrl.run), .duty_i(ctrl.duty), .step_i(step_q), .pwm_o(pwm_o)
);

// File: tb/fan_pwm_top_bench.sv
module fan_pwm_top_bench;
  localparam int unsigned DIV = 2;
  localparam int unsigned PER = 255 * DIV;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        pwm_o;

  int errors = 0;
  int checks = 0;

  fan_pwm_top #(.ADDR_W(4), .DIV(DIV)) u_fan_pwm_top (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .pwm_o
  );

  always #2.5 clk_i = ~clk_i;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    d = rdata_o;
    req_i = 1'b0;
  endtask

  task automatic measure(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      hi += int'(pwm_o);
      @(negedge clk_i);
    end
  endtask

  function automatic logic [31:0] ctl(input logic run, input logic [7:0] duty);
    return {8'h00, duty, 14'h0, 1'b0, run};
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    check(pwm_o == 1'b0, "R1 pwm after reset", pwm_o, 0);
    check(rdata_o == 32'h0, "R1 rdata after reset", rdata_o, 0);
    rd(4'h0, d); check(d == 32'h0, "R1 ctrl reset", d, 0);
    rd(4'h4, d); check(d == 32'd4000, "R1 speed reset", d, 4000);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(4'h0, 32'hFFFF_FFFE);
    rd(4'h0, d); check(d == 32'h00FF_0002, "R2 ctrl readback", d, 32'h00FF_0002);
    check(pwm_o == 1'b0, "R7 stopped output", pwm_o, 0);
    wr(4'h4, 32'hABCD_1234);
    rd(4'h4, d); check(d == 32'h0000_1234, "R3 speed readback", d, 32'h1234);
    wr(4'h8, 32'hFFFF_FFFF);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'h8, d); check(d == 32'h0, "R4 unmapped read", d, 0);
    rd(4'h0, d); check(d == 32'h00FF_0002, "R4 ctrl untouched", d, 32'h00FF_0002);
    rd(4'h4, d); check(d == 32'h0000_1234, "R4 speed untouched", d, 32'h1234);
    wr(4'h0, 32'h0);
  endtask

  task automatic t_duty(input logic [7:0] duty, input string tag);
    int hi;
    wr(4'h0, ctl(1'b1, duty));
    check(pwm_o == (duty != 0), {tag, " period start"}, pwm_o, duty != 0);
    measure(PER, hi);
    check(hi == int'(duty) * DIV, {tag, " high count p1"}, hi, int'(duty) * DIV);
    measure(PER, hi);
    check(hi == int'(duty) * DIV, {tag, " high count p2"}, hi, int'(duty) * DIV);
    wr(4'h0, 32'h0);
  endtask

  task automatic t_mid_change;
    int hi;
    wr(4'h0, ctl(1'b1, 8'd200));
    measure(100, hi);
    check(hi == 100, "R9 before change", hi, 100);
    wr(4'h0, ctl(1'b1, 8'd100));
    measure(PER - 101, hi);
    check(hi == 99, "R9 rest of mixed period", hi, 99);
    measure(PER, hi);
    check(hi == 200, "R9 next period new duty", hi, 200);
    wr(4'h0, 32'h0);
  endtask

  task automatic t_stop_restart;
    int hi;
    wr(4'h0, ctl(1'b1, 8'd10));
    measure(200, hi);
    check(hi == 20, "R5 partial period", hi, 20);
    wr(4'h0, ctl(1'b0, 8'd10));
    check(pwm_o == 1'b0, "R7 low after stop", pwm_o, 0);
    measure(50, hi);
    check(hi == 0, "R7 stays low", hi, 0);
    wr(4'h0, ctl(1'b1, 8'd10));
    check(pwm_o == 1'b1, "R8 restart high at step 0", pwm_o, 1);
    measure(PER, hi);
    check(hi == 20, "R8 fresh period count", hi, 20);
    wr(4'h0, 32'h0);
  endtask

  task automatic t_mode;
    int hi;
    logic [31:0] d;
    wr(4'h0, ctl(1'b1, 8'd128) | 32'h2);
    measure(PER, hi);
    check(hi == 256, "R10 mode bit no effect", hi, 256);
    rd(4'h0, d);
    check(d == 32'h0080_0003, "R10 mode readback", d, 32'h0080_0003);
    wr(4'h0, 32'h0);
  endtask

  task automatic t_full_wrap;
    int hi;
    wr(4'h0, ctl(1'b1, 8'd255));
    measure(3 * PER, hi);
    check(hi == 3 * PER, "R6 duty 255 through wraps", hi, 3 * PER);
    wr(4'h0, 32'h0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_regs();
    t_duty(8'd128, "R5 duty 128");
    t_duty(8'd10,  "R5 duty 10");
    t_duty(8'd0,   "R6 duty 0");
    t_duty(8'd255, "R6 duty 255");
    t_full_wrap();
    t_mid_change();
    t_stop_restart();
    t_mode();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule